// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects up to 24 external interrupt pins, each of which may change at any time with respect to the system clock. It brings every pin into the clock domain and detects an event on each line according to a trigger mode chosen for that line: active-low level, active-high level, falling edge, rising edge or either edge. Detected events are held in a pending register until software clears them. A per-line mask decides whether a pending line reaches the interrupt outputs.

Six interrupt outputs go to a parent interrupt controller. The four lowest lines have one output each. Lines 4 to 7 share the fifth output, and lines 8 to 23 share the sixth. A handler that is woken by a shared output reads the pending register and removes the masked bits to find the source. It then clears the bits it has handled by writing ones to them.

Registers are reached through a flat 32-bit bus with a byte address, a write strobe and a read data path that follows the address within the same cycle.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all three trigger registers read 0, the mask register reads 0x00FFFFFF, the pending register reads 0 and irq_out is 0. The synchronizer stages reset to 1, so pins held high through reset cause no event.
- R2: The trigger field of line i is 4 bits wide and sits in the register at 0x88 + 4*(i/8), bits (i mod 8)*4+3 down to (i mod 8)*4. The mask register is at 0xA4 and the pending register is at 0xA8. All three trigger registers read back what was written, and any other address reads 0.
- R3: Each pin passes through two synchronizing flops. A pin change applied just after clock edge P0 sets pending at edge P3, and the matching irq_out bit rises after P3 and not earlier.
- R4: Edge codes: 4 detects rising edges only, 2 detects falling edges only, and 6, 3, 5 and 7 all detect both edges.
- R5: Level codes: 0 sets pending while the pin is low and 1 sets pending while the pin is high. A line whose level is still active becomes pending again in every cycle.
- R6: Trigger codes 8 to 15 turn off detection for that line, so no pin change makes it pending.
- R7: Writing to the pending register clears each bit written as 1. Bits written as 0 keep their value.
- R8: When an event and a clear for the same line fall in the same cycle, the event wins and the pending bit stays 1.
- R9: A mask bit of 1 keeps that line off irq_out but does not stop it from becoming pending. Clearing the mask bit of a line that is already pending raises its output in the next cycle.
- R10: irq_out[k] for k in 0..3 follows line k alone. irq_out[4] is the OR of lines 4 to 7, and irq_out[5] is the OR of lines 8 to 23, where each line counts only when it is both pending and unmasked.
- R11: Bits 31 to 24 of the mask and pending registers always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 24 | External interrupt pins, asynchronous to clk |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wr | input | 1 | Write strobe, acts at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq_out | output | 6 | Aggregated interrupt requests to the parent controller |

## Verification
A pin change applied one time unit after a clock edge shows up in pending and on irq_out three edges later. The bench checks the output to be still low after the second edge and high after the third. A register write acts at the edge that ends its strobe, and a read is combinational, so every read is queued with its expected value one time unit after an edge and compared at the following falling edge. Where no pin event should occur, the bench waits four edges before it reads pending, so that a late or spurious event would already be visible.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [23:0]       pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [5:0]        irq_out
);
  localparam int NL   = 24;
  localparam int FW   = 4;
  localparam int FPR  = 32 / FW;
  localparam int NCFG = (NL + FPR - 1) / FPR;
  localparam logic [ADDR_W-1:0] CFG_BASE  = ADDR_W'('h88);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'('hA4);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'('hA8);

  logic [NL-1:0]      sync1, sync2, prev;
  logic [NL*FW-1:0]   trig_q;
  logic [NL-1:0]      mask_q, pend_q, evt, act;
  logic               wr_mask, wr_pend;

  assign wr_mask = bus_wr && bus_addr == MASK_ADDR;
  assign wr_pend = bus_wr && bus_addr == PEND_ADDR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
      prev  <= '1;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic [FW-1:0] code;
    assign code = trig_q[i*FW +: FW];
    always_comb
      case (code)
        4'd0:                evt[i] = !sync2[i];
        4'd1:                evt[i] = sync2[i];
        4'd2:                evt[i] = prev[i] && !sync2[i];
        4'd4:                evt[i] = !prev[i] && sync2[i];
        4'd3, 4'd5, 4'd6, 4'd7: evt[i] = prev[i] ^ sync2[i];
        default:             evt[i] = 1'b0;
      endcase
  end

  for (genvar r = 0; r < NCFG; r++) begin : g_cfg
    localparam logic [ADDR_W-1:0] RADDR = CFG_BASE + ADDR_W'(4 * r);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) trig_q[r*32 +: 32] <= '0;
      else if (bus_wr && bus_addr == RADDR) trig_q[r*32 +: 32] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata[NL-1:0];
      pend_q <= (pend_q & ~(wr_pend ? bus_wdata[NL-1:0] : '0)) | evt;
    end

  assign act = pend_q & ~mask_q;
  assign irq_out = {|act[23:8], |act[7:4], act[3:0]};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == MASK_ADDR) bus_rdata = 32'(mask_q);
    else if (bus_addr == PEND_ADDR) bus_rdata = 32'(pend_q);
    else
      for (int r = 0; r < NCFG; r++)
        if (bus_addr == CFG_BASE + ADDR_W'(4 * r)) bus_rdata = trig_q[r*32 +: 32];
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> (pend_q & $past(bus_wdata[NL-1:0] & ~evt)) == '0); // R7
  AST_NO_SPONT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> (pend_q & $past(pend_q)) == $past(pend_q)); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && (bus_wdata[NL-1:0] & evt) != '0)
      |=> (pend_q & $past(bus_wdata[NL-1:0] & evt)) == $past(bus_wdata[NL-1:0] & evt)); // R8
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && bus_wdata[NL-1:0] == '1) |=> irq_out == '0); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == MASK_ADDR || bus_addr == PEND_ADDR) |-> bus_rdata[31:24] == 8'h00); // R11
endmodule

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] pin_in = '1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  irq_out;

  always #2.5 clk = ~clk;

  ext_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
                   .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                   .irq_out(irq_out));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk)
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? bus_rdata : 32'(irq_out);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: %s got 0x%08h expected 0x%08h", it.tag,
                 it.kind == 0 ? "rdata" : "irq_out", act, it.exp);
      end
    end

  task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    cyc(1); chk(0, a, e, tag);
  endtask

  task automatic ir(input logic [5:0] e, input string tag);
    chk(1, 8'h00, 32'(e), tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_wr = 0;
  endtask

  task automatic pin(input int idx, input logic v);
    cyc(1); pin_in[idx] = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc(5);
    rd(8'h88, 0, "R1 cfg0");
    rd(8'h8C, 0, "R1 cfg1");
    rd(8'h90, 0, "R1 cfg2");
    rd(8'hA4, 32'h00FF_FFFF, "R1 mask");
    rd(8'hA8, 0, "R1 pend");
    ir(0, "R1 irq");
    rd(8'h00, 0, "R2 unmapped");

    wr(8'h88, 32'h0020_8134);
    wr(8'h8C, 32'h0006_0040);
    rd(8'h88, 32'h0020_8134, "R2 cfg0 readback");
    rd(8'h8C, 32'h0006_0040, "R2 cfg1 readback");
    pin(2, 0);
    cyc(4);
    wr(8'hA8, 32'h00FF_FFFF);
    rd(8'hA8, 0, "R7 clear all");
    wr(8'hA4, 32'h00EF_EFD0);
    rd(8'hA4, 32'h00EF_EFD0, "R2 mask readback");

    pin(0, 0); cyc(4);
    rd(8'hA8, 0, "R4 rising-only ignores fall");
    pin(0, 1); cyc(2);
    ir(0, "R3 not before third edge");
    cyc(1);
    ir(6'h01, "R3 irq at third edge");
    rd(8'hA8, 32'h1, "R3 pend line0");
    wr(8'hA8, 32'h1);
    rd(8'hA8, 0, "R7 w1c line0");
    ir(0, "R7 irq drops");

    pin(5, 0); cyc(3);
    ir(6'h10, "R10 line5 on out4");
    rd(8'hA8, 32'h20, "R4 falling line5");
    wr(8'hA8, 32'h20);
    pin(5, 1); cyc(4);
    rd(8'hA8, 0, "R4 falling-only ignores rise");

    pin(1, 0); cyc(4);
    rd(8'hA8, 32'h2, "R4 code3 fall");
    wr(8'hA8, 32'h2);
    pin(1, 1); cyc(4);
    rd(8'hA8, 32'h2, "R4 code3 rise");
    ir(6'h02, "R10 line1 own out");
    wr(8'hA8, 32'h2);

    pin(3, 0); cyc(4);
    rd(8'hA8, 0, "R6 code8 fall");
    pin(3, 1); cyc(4);
    rd(8'hA8, 0, "R6 code8 rise");
    ir(0, "R6 irq quiet");

    pin(12, 0); cyc(4);
    rd(8'hA8, 32'h1000, "R4 both-edge fall");
    ir(6'h20, "R10 line12 on out5");
    wr(8'hA8, 32'h1000);
    pin(12, 1); cyc(4);
    rd(8'hA8, 32'h1000, "R4 both-edge rise");
    wr(8'hA8, 32'h1000);

    pin(9, 0); cyc(4);
    pin(9, 1); cyc(4);
    rd(8'hA8, 32'h200, "R9 masked line still pends");
    ir(0, "R9 masked line no irq");
    wr(8'hA4, 32'h00EF_EDD0);
    ir(6'h20, "R9 unmask raises out5");
    wr(8'hA4, 32'h00EF_EFD0);
    wr(8'hA8, 32'h0);
    rd(8'hA8, 32'h200, "R7 zero write no effect");
    wr(8'hA8, 32'h1);
    rd(8'hA8, 32'h200, "R7 other bit no effect");
    wr(8'hA8, 32'h200);
    rd(8'hA8, 0, "R7 clear line9");

    pin(2, 1); cyc(4);
    rd(8'hA8, 32'h4, "R5 level high");
    ir(6'h04, "R10 line2 own out");
    wr(8'hA8, 32'h4);
    rd(8'hA8, 32'h4, "R8 event beats clear");
    pin(2, 0); cyc(4);
    wr(8'hA8, 32'h4);
    rd(8'hA8, 0, "R5 level gone");

    pin(20, 0); cyc(4);
    rd(8'hA8, 32'h10_0000, "R5 level low");
    ir(6'h20, "R10 line20 on out5");
    pin(20, 1); cyc(4);
    wr(8'hA8, 32'h10_0000);
    rd(8'hA8, 0, "R5 level low gone");

    wr(8'hA4, 32'hFFFF_FFFF);
    rd(8'hA4, 32'h00FF_FFFF, "R11 mask upper bits");
    wr(8'hA8, 32'hFF00_0000);
    rd(8'hA8, 0, "R11 pend upper bits");
    ir(0, "R9 all masked");

    cyc(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule